// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps precision time of day as a 32-bit seconds count and a 32-bit nanoseconds count. A 32-bit binary fraction of a nanosecond sits below them. On every reference clock cycle in which the counter is running, a programmable increment is added to the nanosecond accumulator. The increment is in 32.32 fixed-point form: whole nanoseconds above, fraction below. Its nominal value is (10^9 << 32) divided by the reference frequency in Hz. Software trims the frequency by rewriting the increment in either direction.

When the nanosecond field reaches a programmable wrap limit, the limit is subtracted and the remainder is kept, so no time is lost. The seconds count then advances by one. The wrap limit resets to exactly 1,000,000,000.

A small register port controls the block. Writes take effect at the clock edge that samples them. Reads return data one cycle after the request. Reading the seconds register captures the nanosecond value of that same cycle into a snapshot register, so a later nanosecond read is coherent with the seconds value already returned.

A two-state controller (HALT, RUN) follows the enable bit with one cycle of latency. Its transitions are:
- GO: HALT to RUN, when enable is set.
- STOP: RUN to HALT, when enable is cleared.

Time advances only in RUN.

Top module: `ptp_tod_counter`

## Requirements
- R1: A synchronous reset clears the seconds, nanoseconds, fraction, snapshot, enable and increment registers. It sets the wrap limit to 1,000,000,000, puts the controller in HALT and drops rd_valid.
- R2: While running, each clock cycle adds the increment to the time. The whole-nanosecond part (address 2) is added to the nanoseconds, and the fraction part (address 1) is added to the fraction.
- R3: A carry out of the 32-bit fraction adds one nanosecond, and the fraction remainder is retained across cycles. With 2.5 ns per cycle, 11 cycles give 27 ns; with 0.25 ns per cycle, 7 cycles give 1 ns.
- R4: When the sum reaches or exceeds the wrap limit, the nanoseconds become (sum − limit) rather than zero, and the seconds count increments by one.
- R5: With the default limit, the nanosecond value 1,000,000,000 itself wraps to 0 with a seconds increment; 999,999,999 does not wrap.
- R6: The wrap limit is writable at address 3 and reads back the written value.
- R7: An increment write is used by the first accumulation after the write edge. Adjustment works for both larger and smaller values, and a write while halted does not change the time.
- R8: Enable is bit 0 of address 0. A write to address 0 enters RUN one cycle later (GO) and leaves it one cycle later (STOP), so a run from enable-write edge E to disable-write edge D accumulates D − E times. In HALT all time registers hold.
- R9: A read of address 4 (seconds) captures the nanoseconds of the same cycle into a snapshot. Reads of address 5 return the snapshot until the next seconds read.
- R10: A read request (rd_en with rd_addr) produces rd_valid and rd_data on the following cycle. Addresses 0 to 3 return the control, fraction, whole and limit registers; other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one accumulation per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read request |

## Verification
The accumulator is driven with four increment patterns, each separating a different fault:
- A whole-number increment of 8 ns exposes errors in the run length and in GO/STOP latency.
- Fractional increments of 2.5 ns and 0.25 ns expose a lost fraction carry.
- A 30 ns step against a limit of 100 exposes a wrap that zeroes the remainder instead of keeping it.
- A 400,000,000 ns step lands exactly on 10^9 and separates a wrap at the limit from a wrap one count later.

An increment raised mid-run distinguishes immediate from delayed adoption. A seconds read followed by delayed nanosecond reads, while time keeps running, separates a latched snapshot from a live read.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;

    localparam int ADDR_W = 3;
    localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 3'd0,
        A_INC_FRAC = 3'd1,
        A_INC_NS   = 3'd2,
        A_WRAP     = 3'd3,
        A_SEC      = 3'd4,
        A_NS_SNAP  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/ptp_tod_regs.sv
`timescale 1ns/1ps
module ptp_tod_regs
    import ptp_tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NS_W   = 32,
    parameter int FRAC_W = 32,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [NS_W-1:0]   snap_i,
    output logic              en_o,
    output logic [NS_W-1:0]   comp_ns_o,
    output logic [FRAC_W-1:0] comp_frac_o,
    output logic [NS_W-1:0]   limit_o,
    output logic              snap_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    logic              en_q;
    logic [NS_W-1:0]   comp_ns_q;
    logic [FRAC_W-1:0] comp_frac_q;
    logic [NS_W-1:0]   limit_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            comp_ns_q   <= '0;
            comp_frac_q <= '0;
            limit_q     <= NS_W'(NS_PER_SEC);
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:     en_q        <= wr_data[0];
                A_INC_FRAC: comp_frac_q <= FRAC_W'(wr_data);
                A_INC_NS:   comp_ns_q   <= NS_W'(wr_data);
                A_WRAP:     limit_q     <= NS_W'(wr_data);
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:     rd_mux = {{(DATA_W-1){1'b0}}, en_q};
            A_INC_FRAC: rd_mux = DATA_W'(comp_frac_q);
            A_INC_NS:   rd_mux = DATA_W'(comp_ns_q);
            A_WRAP:     rd_mux = DATA_W'(limit_q);
            A_SEC:      rd_mux = DATA_W'(sec_i);
            A_NS_SNAP:  rd_mux = DATA_W'(snap_i);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rd_data_q <= rd_mux;
        end
    end

    always_comb begin
        en_o        = en_q;
        comp_ns_o   = comp_ns_q;
        comp_frac_o = comp_frac_q;
        limit_o     = limit_q;
        snap_o      = rd_en && (rd_addr == A_SEC);
        rd_data_o   = rd_data_q;
        rd_valid_o  = rd_valid_q;
    end

endmodule

// File: rtl/ptp_tod_accum.sv
`timescale 1ns/1ps
module ptp_tod_accum
    import ptp_tod_pkg::*;
#(
    parameter int NS_W   = 32,
    parameter int FRAC_W = 32,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [NS_W-1:0]   comp_ns_i,
    input  logic [FRAC_W-1:0] comp_frac_i,
    input  logic [NS_W-1:0]   limit_i,
    input  logic              snap_i,
    output logic [NS_W-1:0]   ns_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   snap_ns_o,
    output logic              run_o
);

    localparam int SUM_W = NS_W + 1;

    run_state_e        state_q, state_d;
    logic              run;
    logic [NS_W-1:0]   ns_q, ns_next;
    logic [FRAC_W-1:0] frac_q;
    logic [SEC_W-1:0]  sec_q;
    logic [NS_W-1:0]   snap_q;
    logic [FRAC_W:0]   frac_sum;
    logic [SUM_W-1:0]  ns_sum;
    logic              wrap;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    // Next state: GO and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (en_i)  state_d = ST_RUN;
            ST_RUN:  if (!en_i) state_d = ST_HALT;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        run = (state_q == ST_RUN);
        run_o = run;
    end

    // Fixed-point sum and wrap detection
    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, comp_frac_i};
        ns_sum   = {1'b0, ns_q} + {1'b0, comp_ns_i} + SUM_W'(frac_sum[FRAC_W]);
        wrap     = (ns_sum >= {1'b0, limit_i});
        ns_next  = wrap ? NS_W'(ns_sum - {1'b0, limit_i}) : ns_sum[NS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q   <= '0;
            frac_q <= '0;
            sec_q  <= '0;
        end else if (run) begin
            frac_q <= frac_sum[FRAC_W-1:0];
            ns_q   <= ns_next;
            if (wrap) sec_q <= sec_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (snap_i) snap_q <= ns_q;
    end

    always_comb begin
        ns_o      = ns_q;
        frac_o    = frac_q;
        sec_o     = sec_q;
        snap_ns_o = snap_q;
    end

endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NS_W   = 32,
    parameter int FRAC_W = 32,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              en_w;
    logic [NS_W-1:0]   comp_ns_w;
    logic [FRAC_W-1:0] comp_frac_w;
    logic [NS_W-1:0]   limit_w;
    logic              snap_w;
    logic [NS_W-1:0]   ns_w;
    logic [FRAC_W-1:0] frac_w;
    logic [SEC_W-1:0]  sec_w;
    logic [NS_W-1:0]   shadow_w;
    logic              run_w;

    ptp_tod_regs #(
        .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .sec_i(sec_w), .snap_i(shadow_w),
        .en_o(en_w), .comp_ns_o(comp_ns_w), .comp_frac_o(comp_frac_w),
        .limit_o(limit_w), .snap_o(snap_w),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid)
    );

    ptp_tod_accum #(
        .NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)
    ) u_accum (
        .clk(clk), .rst(rst),
        .en_i(en_w), .comp_ns_i(comp_ns_w), .comp_frac_i(comp_frac_w),
        .limit_i(limit_w), .snap_i(snap_w),
        .ns_o(ns_w), .frac_o(frac_w), .sec_o(sec_w),
        .snap_ns_o(shadow_w), .run_o(run_w)
    );

endmodule

// File: rtl/ptp_tod_checker.sv
`timescale 1ns/1ps
module ptp_tod_checker
    import ptp_tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NS_W   = 32,
    parameter int FRAC_W = 32,
    parameter int SEC_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              run_w,
    input logic              snap_w,
    input logic [NS_W-1:0]   ns_w,
    input logic [FRAC_W-1:0] frac_w,
    input logic [SEC_W-1:0]  sec_w,
    input logic [NS_W-1:0]   shadow_w,
    input logic [NS_W-1:0]   comp_ns_w,
    input logic [FRAC_W-1:0] comp_frac_w,
    input logic [NS_W-1:0]   limit_w
);

    logic rst_seen = 1'b0;

    always @(posedge clk) begin
        if (rst_seen) begin
            AST_RESET_CLEARS: assert (sec_w == '0 && ns_w == '0 && frac_w == '0 &&
                                      !run_w && limit_w == NS_W'(NS_PER_SEC)); // R1
        end
        rst_seen <= rst;
    end

    AST_STEP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        run_w |=> (sec_w != $past(sec_w)) ||
                  ({ns_w, frac_w} == $past({ns_w, frac_w}) + $past({comp_ns_w, comp_frac_w}))); // R2

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        run_w |=> (sec_w == $past(sec_w)) || (sec_w == $past(sec_w) + 1'b1)); // R4

    AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (rst)
        !run_w |=> $stable(sec_w) && $stable(ns_w) && $stable(frac_w)); // R8

    AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_WRAP) |=> limit_w == NS_W'($past(wr_data))); // R6

    AST_INC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_INC_NS) |=> comp_ns_w == NS_W'($past(wr_data))); // R7

    AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (rst)
        snap_w |=> shadow_w == $past(ns_w)); // R9

    AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R10

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R10

endmodule

bind ptp_tod_counter ptp_tod_checker #(
    .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)
) u_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .run_w(run_w), .snap_w(snap_w),
    .ns_w(ns_w), .frac_w(frac_w), .sec_w(sec_w), .shadow_w(shadow_w),
    .comp_ns_w(comp_ns_w), .comp_frac_w(comp_frac_w), .limit_w(limit_w)
);

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ptp_tod_counter i_ptp_tod_counter (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Monitor: pops expected values as read data appears
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected rd_valid actual=%0d expected=none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s actual=%0d expected=%0d", t, rd_data, e);
                end
            end
        end
    end

    // All tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, 32'd0, "R1 ctrl");
        rd(3'd1, 32'd0, "R1 inc_frac");
        rd(3'd2, 32'd0, "R1 inc_ns");
        rd(3'd3, 32'd1_000_000_000, "R1 wrap default");
        rd(3'd4, 32'd0, "R1 sec");
        rd(3'd5, 32'd0, "R1 ns");
        rd(3'd7, 32'd0, "R10 unused addr");

        // R2 / R8 integer increment, 10 accumulations
        wr(3'd2, 32'd8);
        wr(3'd0, 32'd1);
        idle(9);
        wr(3'd0, 32'd0);
        idle(3);
        rd(3'd4, 32'd0, "R2 sec");
        rd(3'd5, 32'd80, "R2 ns 8x10");
        idle(5);
        rd(3'd4, 32'd0, "R8 sec held");
        rd(3'd5, 32'd80, "R8 ns held");
        rd(3'd0, 32'd0, "R10 ctrl readback");

        // R3 fraction 2.5 ns, 11 accumulations
        do_reset();
        wr(3'd1, 32'h8000_0000);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'd1);
        idle(10);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd1, 32'h8000_0000, "R10 inc_frac readback");
        rd(3'd4, 32'd0, "R3 sec");
        rd(3'd5, 32'd27, "R3 ns 2.5x11");

        // R3 pure fraction 0.25 ns, 7 accumulations
        do_reset();
        wr(3'd1, 32'h4000_0000);
        wr(3'd0, 32'd1);
        idle(6);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd4, 32'd0, "R3 sec frac only");
        rd(3'd5, 32'd1, "R3 ns 0.25x7");

        // R4 / R6 wrap at 100 keeps remainder, 7 x 30
        do_reset();
        wr(3'd3, 32'd100);
        wr(3'd2, 32'd30);
        wr(3'd0, 32'd1);
        idle(6);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd3, 32'd100, "R6 wrap readback");
        rd(3'd4, 32'd2, "R4 sec after two wraps");
        rd(3'd5, 32'd10, "R4 ns remainder");

        // R5 exact wrap at 1e9, 5 x 4e8
        do_reset();
        wr(3'd2, 32'd400_000_000);
        wr(3'd0, 32'd1);
        idle(4);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd4, 32'd2, "R5 sec");
        rd(3'd5, 32'd0, "R5 ns at 1e9 wraps to 0");

        // R7 increment raised mid-run, then lowered while halted
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'd20);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd4, 32'd0, "R7 sec");
        rd(3'd5, 32'd40, "R7 new inc used at once");
        wr(3'd2, 32'd5);
        idle(2);
        rd(3'd4, 32'd0, "R7 sec halted write");
        rd(3'd5, 32'd40, "R7 halted write no time change");
        wr(3'd0, 32'd1);
        idle(2);
        wr(3'd0, 32'd0);
        idle(2);
        rd(3'd4, 32'd0, "R7 sec lowered");
        rd(3'd5, 32'd55, "R7 lowered inc 3x5");

        // R9 coherent snapshot while running
        do_reset();
        wr(3'd3, 32'd100);
        wr(3'd2, 32'd30);
        wr(3'd0, 32'd1);
        idle(6);
        rd(3'd4, 32'd1, "R9 sec at snapshot");
        rd(3'd5, 32'd50, "R9 snapshot next cycle");
        idle(2);
        rd(3'd5, 32'd50, "R9 snapshot later");
        wr(3'd0, 32'd0);

        // R1 reset during activity
        wr(3'd0, 32'd1);
        idle(3);
        do_reset();
        idle(2);
        rd(3'd4, 32'd0, "R1 sec after reset");
        rd(3'd5, 32'd0, "R1 snapshot after reset");
        rd(3'd0, 32'd0, "R1 ctrl after reset");
        rd(3'd3, 32'd1_000_000_000, "R1 wrap after reset");

        idle(3);
        finish_run();
    end

endmodule